// File: doc/BRIEF.md
# Privilege-Banked Stack Pointer Unit

This unit keeps two stack pointers, one for supervisor code and one for user code, behind a single architectural stack-pointer register. The privilege input decides which of the two is visible. While one is selected the other cannot be read or written through that register. Both stacks grow toward lower addresses. A push first lowers the selected pointer and then writes at the new address. A pop reads at the current address and then raises the pointer.

The unit also runs the multi-word stack traffic of control transfers. A subroutine call writes the program counter onto the selected stack, and a return reads it back. Trap or interrupt entry always stacks onto the supervisor pointer. It first asks the surrounding logic to enter supervisor state, then writes the program counter and the pre-entry status word. Return-from-exception reads the status word and then the program counter back. The restored values are presented on outputs for the surrounding core to apply.

The memory port issues at most one access per cycle and expects read data in the same cycle. Data is right-justified on the data bus, and the byte enables show which low lanes are valid.

Top module: `stack_bank_unit`

## Requirements
- R1: After reset the supervisor pointer equals `rst_ssp` and the user pointer is zero. `set_super` stays high from reset until the first clock after the internal reset release, and `busy` is low.
- R2: With `priv`=1, `sp_rd` shows the supervisor pointer, and stack-pointer writes and stack accesses change only the supervisor pointer.
- R3: With `priv`=0, `sp_rd` shows the user pointer, and stack-pointer writes and stack accesses change only the user pointer.
- R4: A push lowers the active pointer by the step and writes at the lowered address. The step is 2 for `op_size`=00 (byte) and 01 (word), and 4 for 10 or 11 (long). The byte enables are 0001, 0011 and 1111 for byte, word and long, and the write data is masked to the enabled lanes.
- R5: A pop reads at the active pointer and then raises the pointer by the same step as R4.
- R6: A call writes `pc_in` as a long at active pointer minus 4. A return reads a long at the active pointer and adds 4. `restored_pc` and a one-cycle `restore_pc_valid` appear in the cycle after the read.
- R7: Exception entry ignores `priv`. It raises `set_super` in its first cycle and writes `pc_in` as a long at supervisor pointer minus 4. In the next cycle it writes the `sr_in` value captured at the request, as a word, at supervisor pointer minus 6. The supervisor pointer ends 6 lower and the user pointer is untouched.
- R8: Return-from-exception reads the status word at the active pointer and then the long program counter at that pointer plus 2, and the pointer ends 6 higher. `restored_sr`, `restored_pc` and both valid pulses appear in the cycle after the second read.
- R9: When several requests coincide, only one is served, in this order: exception, return-from-exception, return, call, pop, push, stack-pointer write.
- R10: `busy` is high in both cycles of an exception entry or a return-from-exception. Any request presented in the second cycle is ignored.
- R11: The pointer used by both cycles of a sequence is chosen when the sequence starts. A change of `priv`, including one caused by a restored status word, affects only accesses that start later.
- R12: Pointer arithmetic wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_ssp | input | AW | Supervisor pointer value loaded at reset |
| priv | input | 1 | 1 = supervisor state, 0 = user state |
| req_push | input | 1 | Push request |
| req_pop | input | 1 | Pop request |
| op_size | input | 2 | Push/pop size: 00 byte, 01 word, 1x long |
| push_data | input | DW | Data to push, right-justified |
| req_call | input | 1 | Subroutine call request |
| req_ret | input | 1 | Subroutine return request |
| req_exc | input | 1 | Trap/interrupt entry request |
| req_rte | input | 1 | Return-from-exception request |
| pc_in | input | DW | Program counter to stack |
| sr_in | input | SRW | Status register to stack on exception |
| req_spwr | input | 1 | Write the active stack pointer |
| sp_wr_data | input | AW | Value for the stack-pointer write |
| sp_rd | output | AW | Active stack pointer |
| busy | output | 1 | Multi-cycle sequence in progress |
| set_super | output | 1 | Request to enter supervisor state |
| mem_valid | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_be | output | DW/8 | Byte enables, right-justified |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, same cycle |
| restored_pc | output | DW | Program counter read by return / return-from-exception |
| restore_pc_valid | output | 1 | One-cycle strobe for `restored_pc` |
| restored_sr | output | SRW | Status word read by return-from-exception |
| restore_sr_valid | output | 1 | One-cycle strobe for `restored_sr` |

## Verification
The bench builds the unit with AW=16 and DW=32. The narrow address lets a pointer step below zero and wrap within reach, and a small byte-array memory can model every access. It sweeps each operand size under both privilege settings and checks that the unselected pointer does not move. It then runs exception entry from user state with a push offered mid-sequence, and return-from-exception with `priv` toggled between the two reads. Expected addresses and pointer values are computed arithmetically from the step sizes.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } sz_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_EXC_SR = 2'b01,
    ST_RTE_PC = 2'b10
  } seq_st_e;

  typedef enum logic [1:0] {
    SRC_PUSH = 2'b00,
    SRC_PC   = 2'b01,
    SRC_SR   = 2'b10
  } wsrc_e;

  // pointer step in bytes: bytes and words keep word alignment
  function automatic logic [2:0] step_of(input logic [1:0] sz);
    return sz[1] ? 3'd4 : 3'd2;
  endfunction

  // number of data bytes moved
  function automatic logic [2:0] nbytes_of(input logic [1:0] sz);
    return sz[1] ? 3'd4 : (sz[0] ? 3'd2 : 3'd1);
  endfunction

endpackage

// File: rtl/sbu_ptr_bank.sv
module sbu_ptr_bank #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rst_ssp,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_val,
  output logic [AW-1:0] ssp,
  output logic [AW-1:0] usp
);

  localparam int NBANK = 2;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_d;
    logic          ptr_en;
    logic [AW-1:0] rst_val;

    assign rst_val = (b == 1) ? rst_ssp : '0;
    assign ptr_en  = wr_en && (wr_bank == 1'(b));
    assign ptr_d   = wr_val;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q <= rst_val;
      else if (ptr_en) ptr_q <= ptr_d;
    end
  end

  assign ssp = g_bank[1].ptr_q;
  assign usp = g_bank[0].ptr_q;

endmodule

// File: rtl/sbu_seq.sv
module sbu_seq
  import sbu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       priv,
  input  logic       req_exc,
  input  logic       req_rte,
  input  logic       req_ret,
  input  logic       req_call,
  input  logic       req_pop,
  input  logic       req_push,
  input  logic       req_spwr,
  input  logic [1:0] op_size,
  output logic       acc_valid,
  output logic       acc_we,
  output logic [1:0] acc_sz,
  output logic       acc_bank,
  output logic       acc_predec,
  output wsrc_e      acc_src,
  output logic       cap_hold,
  output logic       cap_sr,
  output logic       cap_pc,
  output logic       spwr_go,
  output logic       busy,
  output logic       set_super,
  output logic       idle,
  output logic       pc_done,
  output logic       sr_done
);

  seq_st_e st_q, st_d;
  logic    bank_q, bank_d;
  logic    pc_done_q, pc_done_d;
  logic    sr_done_q, sr_done_d;
  logic    boot_q;
  logic    exc_start;

  always_comb begin
    st_d       = st_q;
    bank_d     = bank_q;
    pc_done_d  = 1'b0;
    sr_done_d  = 1'b0;
    acc_valid  = 1'b0;
    acc_we     = 1'b0;
    acc_sz     = SZ_LONG;
    acc_bank   = priv;
    acc_predec = 1'b0;
    acc_src    = SRC_PUSH;
    cap_hold   = 1'b0;
    cap_sr     = 1'b0;
    cap_pc     = 1'b0;
    spwr_go    = 1'b0;
    busy       = 1'b0;
    exc_start  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_exc) begin
          exc_start  = 1'b1;
          acc_valid  = 1'b1;
          acc_we     = 1'b1;
          acc_bank   = 1'b1;
          acc_predec = 1'b1;
          acc_src    = SRC_PC;
          cap_hold   = 1'b1;
          busy       = 1'b1;
          st_d       = ST_EXC_SR;
        end else if (req_rte) begin
          acc_valid  = 1'b1;
          acc_sz     = SZ_WORD;
          cap_sr     = 1'b1;
          busy       = 1'b1;
          bank_d     = priv;
          st_d       = ST_RTE_PC;
        end else if (req_ret) begin
          acc_valid  = 1'b1;
          cap_pc     = 1'b1;
          pc_done_d  = 1'b1;
        end else if (req_call) begin
          acc_valid  = 1'b1;
          acc_we     = 1'b1;
          acc_predec = 1'b1;
          acc_src    = SRC_PC;
        end else if (req_pop) begin
          acc_valid  = 1'b1;
          acc_sz     = op_size;
        end else if (req_push) begin
          acc_valid  = 1'b1;
          acc_we     = 1'b1;
          acc_sz     = op_size;
          acc_predec = 1'b1;
        end else if (req_spwr) begin
          spwr_go    = 1'b1;
        end
      end
      ST_EXC_SR: begin
        acc_valid  = 1'b1;
        acc_we     = 1'b1;
        acc_sz     = SZ_WORD;
        acc_bank   = 1'b1;
        acc_predec = 1'b1;
        acc_src    = SRC_SR;
        busy       = 1'b1;
        st_d       = ST_IDLE;
      end
      ST_RTE_PC: begin
        acc_valid  = 1'b1;
        acc_bank   = bank_q;
        cap_pc     = 1'b1;
        busy       = 1'b1;
        pc_done_d  = 1'b1;
        sr_done_d  = 1'b1;
        st_d       = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      bank_q    <= 1'b1;
      pc_done_q <= 1'b0;
      sr_done_q <= 1'b0;
      boot_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      bank_q    <= bank_d;
      pc_done_q <= pc_done_d;
      sr_done_q <= sr_done_d;
      boot_q    <= 1'b1;
    end
  end

  assign set_super = exc_start || (st_q == ST_EXC_SR) || !boot_q;
  assign idle      = (st_q == ST_IDLE);
  assign pc_done   = pc_done_q;
  assign sr_done   = sr_done_q;

endmodule

// File: rtl/sbu_capture.sv
module sbu_capture #(
  parameter int DW  = 32,
  parameter int SRW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_hold,
  input  logic           cap_sr,
  input  logic           cap_pc,
  input  logic [SRW-1:0] sr_in,
  input  logic [DW-1:0]  rdata,
  output logic [SRW-1:0] sr_hold,
  output logic [SRW-1:0] sr_back,
  output logic [DW-1:0]  pc_back
);

  logic [SRW-1:0] hold_q, srb_q;
  logic [DW-1:0]  pcb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (cap_hold) hold_q <= sr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      srb_q <= '0;
    else if (cap_sr) srb_q <= rdata[SRW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcb_q <= '0;
    else if (cap_pc) pcb_q <= rdata;
  end

  assign sr_hold = hold_q;
  assign sr_back = srb_q;
  assign pc_back = pcb_q;

endmodule

// File: rtl/stack_bank_unit.sv
module stack_bank_unit
  import sbu_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int SRW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rst_ssp,
  input  logic            priv,
  input  logic            req_push,
  input  logic            req_pop,
  input  logic [1:0]      op_size,
  input  logic [DW-1:0]   push_data,
  input  logic            req_call,
  input  logic            req_ret,
  input  logic            req_exc,
  input  logic            req_rte,
  input  logic [DW-1:0]   pc_in,
  input  logic [SRW-1:0]  sr_in,
  input  logic            req_spwr,
  input  logic [AW-1:0]   sp_wr_data,
  output logic [AW-1:0]   sp_rd,
  output logic            busy,
  output logic            set_super,
  output logic            mem_valid,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW/8-1:0] mem_be,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [DW-1:0]   restored_pc,
  output logic            restore_pc_valid,
  output logic [SRW-1:0]  restored_sr,
  output logic            restore_sr_valid
);

  localparam int BE_W = DW / 8;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic           acc_valid, acc_we, acc_bank, acc_predec;
  logic [1:0]     acc_sz;
  wsrc_e          acc_src;
  logic           cap_hold, cap_sr, cap_pc, spwr_go;
  logic           seq_idle;
  logic [SRW-1:0] sr_hold;
  logic [AW-1:0]  ssp, usp;

  sbu_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .priv       (priv),
    .req_exc    (req_exc),
    .req_rte    (req_rte),
    .req_ret    (req_ret),
    .req_call   (req_call),
    .req_pop    (req_pop),
    .req_push   (req_push),
    .req_spwr   (req_spwr),
    .op_size    (op_size),
    .acc_valid  (acc_valid),
    .acc_we     (acc_we),
    .acc_sz     (acc_sz),
    .acc_bank   (acc_bank),
    .acc_predec (acc_predec),
    .acc_src    (acc_src),
    .cap_hold   (cap_hold),
    .cap_sr     (cap_sr),
    .cap_pc     (cap_pc),
    .spwr_go    (spwr_go),
    .busy       (busy),
    .set_super  (set_super),
    .idle       (seq_idle),
    .pc_done    (restore_pc_valid),
    .sr_done    (restore_sr_valid)
  );

  // address generation
  logic [AW-1:0] cur_sp, step, eff_addr, new_sp;
  logic          pb_wr_en, pb_wr_bank;
  logic [AW-1:0] pb_wr_val;

  always_comb begin
    cur_sp   = acc_bank ? ssp : usp;
    step     = AW'(step_of(acc_sz));
    eff_addr = acc_predec ? (cur_sp - step) : cur_sp;
    new_sp   = acc_predec ? (cur_sp - step) : (cur_sp + step);
  end

  always_comb begin
    pb_wr_en   = acc_valid || spwr_go;
    pb_wr_bank = acc_valid ? acc_bank : priv;
    pb_wr_val  = acc_valid ? new_sp : sp_wr_data;
  end

  sbu_ptr_bank #(.AW(AW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rst_ssp (rst_ssp),
    .wr_en   (pb_wr_en),
    .wr_bank (pb_wr_bank),
    .wr_val  (pb_wr_val),
    .ssp     (ssp),
    .usp     (usp)
  );

  sbu_capture #(.DW(DW), .SRW(SRW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cap_hold (cap_hold),
    .cap_sr   (cap_sr),
    .cap_pc   (cap_pc),
    .sr_in    (sr_in),
    .rdata    (mem_rdata),
    .sr_hold  (sr_hold),
    .sr_back  (restored_sr),
    .pc_back  (restored_pc)
  );

  // byte enables and write data, right-justified lanes
  logic [2:0]    nb;
  logic [DW-1:0] lane_mask;
  logic [DW-1:0] src_data;

  assign nb = nbytes_of(acc_sz);

  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign mem_be[i]          = (i < int'(nb));
    assign lane_mask[8*i +: 8] = {8{mem_be[i]}};
  end

  always_comb begin
    unique case (acc_src)
      SRC_PC:  src_data = pc_in;
      SRC_SR:  src_data = DW'(sr_hold);
      default: src_data = push_data;
    endcase
  end

  assign mem_valid = acc_valid;
  assign mem_we    = acc_we;
  assign mem_addr  = eff_addr;
  assign mem_wdata = src_data & lane_mask;
  assign sp_rd     = priv ? ssp : usp;

endmodule

// File: rtl/sbu_checks.sv
module sbu_checks
  import sbu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int BE_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            idle,
  input logic            priv,
  input logic            req_exc,
  input logic            req_rte,
  input logic            req_ret,
  input logic            req_call,
  input logic            req_pop,
  input logic            req_push,
  input logic [1:0]      op_size,
  input logic            busy,
  input logic            mem_valid,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [BE_W-1:0] mem_be,
  input logic [AW-1:0]   sp_rd,
  input logic            restore_sr_valid,
  input logic            restore_pc_valid
);

  logic hi_pri;
  assign hi_pri = req_exc || req_rte || req_ret || req_call;

  // R4: a push addresses one step below the visible pointer
  assert_push_predec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idle && req_push && !hi_pri && !req_pop |->
      mem_valid && mem_we && (mem_addr == sp_rd - AW'(step_of(op_size))));

  // R5: a pop raises the pointer by one step unless privilege changed
  assert_pop_postinc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle && req_pop && !hi_pri |=>
      (priv != $past(priv)) || (sp_rd == $past(sp_rd) + AW'(step_of($past(op_size)))));

  // R7: second exception write is the status word just below the PC
  assert_exc_sr_below_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idle && req_exc |=>
      busy && mem_we && (mem_addr == $past(mem_addr) - AW'(2)) && (mem_be == BE_W'(3)));

  // R8: restored status only after a busy sequence, together with the PC
  assert_restore_after_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_sr_valid |-> restore_pc_valid && $past(busy));

  // R10: busy covers the second cycle of every sequence
  assert_busy_in_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> busy && mem_valid);

endmodule

bind stack_bank_unit sbu_checks #(.AW(AW), .BE_W(DW/8)) u_chk (
  .clk              (clk),
  .rst_n            (rst_sync_n),
  .idle             (seq_idle),
  .priv             (priv),
  .req_exc          (req_exc),
  .req_rte          (req_rte),
  .req_ret          (req_ret),
  .req_call         (req_call),
  .req_pop          (req_pop),
  .req_push         (req_push),
  .op_size          (op_size),
  .busy             (busy),
  .mem_valid        (mem_valid),
  .mem_we           (mem_we),
  .mem_addr         (mem_addr),
  .mem_be           (mem_be),
  .sp_rd            (sp_rd),
  .restore_sr_valid (restore_sr_valid),
  .restore_pc_valid (restore_pc_valid)
);

// File: tb/sim_stack_bank_unit.sv
module sim_stack_bank_unit;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int DW  = 32;
  localparam int SRW = 16;
  localparam int BEW = DW / 8;

  logic            clk;
  logic            rst_n;
  logic [AW-1:0]   rst_ssp;
  logic            priv;
  logic            req_push, req_pop, req_call, req_ret, req_exc, req_rte, req_spwr;
  logic [1:0]      op_size;
  logic [DW-1:0]   push_data, pc_in;
  logic [SRW-1:0]  sr_in;
  logic [AW-1:0]   sp_wr_data;
  logic [AW-1:0]   sp_rd;
  logic            busy, set_super;
  logic            mem_valid, mem_we;
  logic [AW-1:0]   mem_addr;
  logic [BEW-1:0]  mem_be;
  logic [DW-1:0]   mem_wdata, mem_rdata;
  logic [DW-1:0]   restored_pc;
  logic            restore_pc_valid;
  logic [SRW-1:0]  restored_sr;
  logic            restore_sr_valid;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  stack_bank_unit #(.AW(AW), .DW(DW), .SRW(SRW)) u0 (
    .clk(clk), .rst_n(rst_n), .rst_ssp(rst_ssp), .priv(priv),
    .req_push(req_push), .req_pop(req_pop), .op_size(op_size), .push_data(push_data),
    .req_call(req_call), .req_ret(req_ret), .req_exc(req_exc), .req_rte(req_rte),
    .pc_in(pc_in), .sr_in(sr_in), .req_spwr(req_spwr), .sp_wr_data(sp_wr_data),
    .sp_rd(sp_rd), .busy(busy), .set_super(set_super),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .restored_pc(restored_pc), .restore_pc_valid(restore_pc_valid),
    .restored_sr(restored_sr), .restore_sr_valid(restore_sr_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // byte-array memory, 1 KiB window, same-cycle read
  logic [7:0] mem [1024];
  initial for (int i = 0; i < 1024; i++) mem[i] = 8'h00;

  always @(posedge clk) begin
    if (mem_valid && mem_we)
      for (int i = 0; i < BEW; i++)
        if (mem_be[i]) mem[10'(mem_addr[9:0] + 10'(i))] <= mem_wdata[8*i +: 8];
  end

  always_comb begin
    for (int i = 0; i < BEW; i++)
      mem_rdata[8*i +: 8] = mem[10'(mem_addr[9:0] + 10'(i))];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clear_reqs();
    req_push = 0; req_pop = 0; req_call = 0; req_ret = 0;
    req_exc = 0; req_rte = 0; req_spwr = 0;
  endtask

  function automatic logic [AW-1:0] step_exp(input logic [1:0] s);
    return (s >= 2) ? AW'(4) : AW'(2);
  endfunction

  function automatic logic [BEW-1:0] be_exp(input logic [1:0] s);
    return (s == 0) ? 4'b0001 : (s == 1) ? 4'b0011 : 4'b1111;
  endfunction

  function automatic logic [DW-1:0] mask_exp(input logic [1:0] s);
    return (s == 0) ? 32'h0000_00FF : (s == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [AW-1:0] base, other;
    logic [DW-1:0] d;
    clear_reqs();
    rst_n = 0; rst_ssp = 16'h0300; priv = 1; op_size = 0;
    push_data = 0; pc_in = 0; sr_in = 0; sp_wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R1 reset state
    chk(sp_rd == 16'h0300, "R1 ssp reset", 32'(sp_rd), 32'h300);
    chk(set_super == 1'b1, "R1 set_super", 32'(set_super), 1);
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    repeat (4) @(negedge clk); #1;
    chk(set_super == 1'b0, "R1 set_super release", 32'(set_super), 0);
    priv = 0; #1;
    chk(sp_rd == 16'h0000, "R1 usp reset", 32'(sp_rd), 0);

    // R3 write user pointer, R2 supervisor unaffected
    @(negedge clk); req_spwr = 1; sp_wr_data = 16'h0200;
    @(negedge clk); clear_reqs(); #1;
    chk(sp_rd == 16'h0200, "R3 usp write", 32'(sp_rd), 32'h200);
    priv = 1; #1;
    chk(sp_rd == 16'h0300, "R2 ssp untouched", 32'(sp_rd), 32'h300);

    // R4/R5 sweep both banks and all sizes
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk);
        priv = p[0]; #1;
        base = sp_rd;
        priv = ~p[0]; #1; other = sp_rd; priv = p[0];
        d = 32'hA5C3_1E00 | 32'(p * 16 + s + 1) | 32'h5A00_0000;
        req_push = 1; op_size = s[1:0]; push_data = d; #1;
        chk(mem_valid && mem_we, "R4 push write", 32'({mem_valid, mem_we}), 3);
        chk(mem_addr == base - step_exp(s[1:0]), "R4 push addr", 32'(mem_addr), 32'(base - step_exp(s[1:0])));
        chk(mem_be == be_exp(s[1:0]), "R4 push be", 32'(mem_be), 32'(be_exp(s[1:0])));
        chk(mem_wdata == (d & mask_exp(s[1:0])), "R4 push data", mem_wdata, d & mask_exp(s[1:0]));
        @(negedge clk); clear_reqs(); #1;
        chk(sp_rd == base - step_exp(s[1:0]), "R4 push ptr", 32'(sp_rd), 32'(base - step_exp(s[1:0])));
        priv = ~p[0]; #1;
        chk(sp_rd == other, p ? "R2 other bank" : "R3 other bank", 32'(sp_rd), 32'(other));
        priv = p[0];
        req_pop = 1; op_size = s[1:0]; #1;
        chk(!mem_we && mem_addr == base - step_exp(s[1:0]), "R5 pop addr", 32'(mem_addr), 32'(base - step_exp(s[1:0])));
        chk((mem_rdata & mask_exp(s[1:0])) == (d & mask_exp(s[1:0])), "R5 pop data",
            mem_rdata & mask_exp(s[1:0]), d & mask_exp(s[1:0]));
        @(negedge clk); clear_reqs(); #1;
        chk(sp_rd == base, "R5 pop ptr", 32'(sp_rd), 32'(base));
      end
    end

    // R6 call/return on user stack
    priv = 0; #1; base = sp_rd;
    req_call = 1; pc_in = 32'h00C0_FFEE; #1;
    chk(mem_we && mem_addr == base - 4 && mem_wdata == 32'h00C0_FFEE, "R6 call write", 32'(mem_addr), 32'(base - 4));
    @(negedge clk); clear_reqs(); #1;
    chk(sp_rd == base - 4, "R6 call ptr", 32'(sp_rd), 32'(base - 4));
    req_ret = 1; #1;
    chk(!mem_we && mem_addr == base - 4, "R6 ret addr", 32'(mem_addr), 32'(base - 4));
    @(negedge clk); clear_reqs(); #1;
    chk(restore_pc_valid && restored_pc == 32'h00C0_FFEE, "R6 restored pc", restored_pc, 32'h00C0_FFEE);
    chk(sp_rd == base, "R6 ret ptr", 32'(sp_rd), 32'(base));
    @(negedge clk); #1;
    chk(!restore_pc_valid, "R6 valid pulse", 32'(restore_pc_valid), 0);

    // R7 exception from user state, R10 push ignored in second cycle
    req_exc = 1; pc_in = 32'h1234_ABCD; sr_in = 16'h0015; #1;
    chk(set_super && busy, "R7 set_super", 32'({set_super, busy}), 3);
    chk(mem_we && mem_addr == 16'h02FC && mem_be == 4'hF && mem_wdata == 32'h1234_ABCD,
        "R7 pc write", 32'(mem_addr), 32'h2FC);
    @(negedge clk); clear_reqs(); sr_in = 16'hFFFF; req_push = 1; op_size = 2; push_data = 32'hDEAD_BEEF; #1;
    chk(busy, "R10 busy second", 32'(busy), 1);
    chk(mem_we && mem_addr == 16'h02FA && mem_be == 4'h3 && mem_wdata == 32'h0000_0015,
        "R7 sr write", mem_wdata, 32'h15);
    @(negedge clk); clear_reqs(); #1;
    chk(!busy, "R10 busy end", 32'(busy), 0);
    chk(sp_rd == 16'h0200, "R7 usp untouched", 32'(sp_rd), 32'h200);
    priv = 1; #1;
    chk(sp_rd == 16'h02FA, "R10 ssp after exc", 32'(sp_rd), 32'h2FA);

    // R8 return from exception, R11 priv change mid-sequence
    @(negedge clk); req_rte = 1; #1;
    chk(busy && !mem_we && mem_addr == 16'h02FA, "R8 sr read", 32'(mem_addr), 32'h2FA);
    @(negedge clk); clear_reqs(); priv = 0; #1;
    chk(busy && !mem_we && mem_addr == 16'h02FC, "R11 pc read bank", 32'(mem_addr), 32'h2FC);
    @(negedge clk); #1;
    chk(restore_sr_valid && restored_sr == 16'h0015, "R8 restored sr", 32'(restored_sr), 32'h15);
    chk(restore_pc_valid && restored_pc == 32'h1234_ABCD, "R8 restored pc", restored_pc, 32'h1234_ABCD);
    chk(sp_rd == 16'h0200, "R11 usp untouched", 32'(sp_rd), 32'h200);
    priv = 1; #1;
    chk(sp_rd == 16'h0300, "R8 ssp restored", 32'(sp_rd), 32'h300);

    // R9 priority
    @(negedge clk); req_push = 1; req_pop = 1; op_size = 2; #1;
    chk(!mem_we && mem_addr == 16'h0300, "R9 pop over push", 32'(mem_addr), 32'h300);
    @(negedge clk); clear_reqs(); #1;
    chk(sp_rd == 16'h0304, "R9 pop ptr", 32'(sp_rd), 32'h304);
    priv = 0; req_call = 1; req_exc = 1; pc_in = 32'h0000_1111; sr_in = 16'h0004; #1;
    chk(mem_addr == 16'h0300, "R9 exc over call", 32'(mem_addr), 32'h300);
    @(negedge clk); clear_reqs(); @(negedge clk); #1;
    chk(sp_rd == 16'h0200, "R9 call dropped", 32'(sp_rd), 32'h200);
    priv = 1; req_spwr = 1; sp_wr_data = 16'h0100; req_push = 1; op_size = 1; #1;
    chk(mem_valid && mem_addr == 16'h02FC, "R9 push over spwr", 32'(mem_addr), 32'h2FC);
    @(negedge clk); clear_reqs(); #1;
    chk(sp_rd == 16'h02FC, "R9 spwr dropped", 32'(sp_rd), 32'h2FC);

    // R12 wrap
    req_spwr = 1; sp_wr_data = 16'h0000;
    @(negedge clk); clear_reqs(); req_push = 1; op_size = 2; push_data = 32'h0BAD_F00D; #1;
    chk(mem_addr == 16'hFFFC, "R12 wrap down", 32'(mem_addr), 32'hFFFC);
    @(negedge clk); clear_reqs(); #1;
    chk(sp_rd == 16'hFFFC, "R12 wrapped ptr", 32'(sp_rd), 32'hFFFC);
    req_pop = 1; op_size = 2; #1;
    chk(mem_rdata == 32'h0BAD_F00D, "R12 wrap data", mem_rdata, 32'h0BAD_F00D);
    @(negedge clk); clear_reqs(); #1;
    chk(sp_rd == 16'h0000, "R12 wrap up", 32'(sp_rd), 0);

    @(negedge clk);
    finish_run();
  end

endmodule